// File: doc/BRIEF.md
# Dual-Mode Identification Data Channel

This block is the display side of a monitor's identification channel. It holds a 128-byte identification table and runs on a fast system clock. The VCLK, SCL and SDA lines pass through two-flop synchronizers, and their edges are found in the system clock domain. The block pulls SDA low through an open-drain enable and never drives it high.

After reset the block streams the table on its own. Each VCLK pulse sends one bit, and no request is needed. When SCL falls, the block stops streaming and becomes a two-wire slave. As a slave it can write the table at any address, with a hardware write-protect input that blocks writes. It can also read the table sequentially from the current pointer. While in slave mode it counts VCLK cycles. A valid control byte clears that count. If the count expires first, the block falls back to streaming.

Top module: `edid_dual_chan`

## Requirements
- R1: During and after reset the block is in streaming mode (`bidir_mode_o`=0) with SDA released (`sda_oe_o`=0) and the byte pointer at 0.
- R2: In streaming mode each VCLK rising edge drives the next bit of the byte at the pointer, MSB first. The ninth bit of each byte is released high. SDA does not change between VCLK rising edges.
- R3: Table entry i holds (i*29+7) mod 256 after reset. The streaming pointer advances once per nine bits and wraps from 127 to 0.
- R4: A falling SCL edge in streaming mode moves the block to slave mode with SDA released. A partly sent byte is abandoned and the pointer keeps its value.
- R5: A control byte whose upper four bits are 1010 is acknowledged (SDA pulled low in the ninth clock). Bits 3..1 are don't-care, and bit 0 selects read (1) or write (0). Any other control byte gets no acknowledge and changes neither the pointer nor the table.
- R6: In slave mode, 128 VCLK rising edges with no acknowledged control byte return the block to streaming mode with SDA released. An acknowledged control byte restarts the count, and a rejected one does not.
- R7: After a write control byte, the next byte loads bits 6..0 into the pointer. Each following data byte is acknowledged, stored at the pointer, and advances the pointer with wrap at 128.
- R8: While `wp_i` is high, data bytes are still acknowledged and still advance the pointer, but the table is not changed.
- R9: After a read control byte, bytes are sent MSB first from the pointer with auto-increment and wrap. After the master gives no acknowledge, the slave releases SDA and waits for a START.
- R10: On return to streaming, the stream restarts with a fresh byte at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vclk_i | input | 1 | Stream bit clock (asynchronous) |
| scl_i | input | 1 | Two-wire clock line (asynchronous) |
| sda_i | input | 1 | Two-wire data line as seen on the wire |
| wp_i | input | 1 | Write protect; high blocks table writes |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| bidir_mode_o | output | 1 | 1 while in two-wire slave mode |

## Verification
The bench builds the block with its default parameters: a table depth of 128 and a VCLK limit of 128. With these values the whole table can be streamed within the run. That covers the 127-to-0 wrap in streaming mode and also in sequential reads and writes. It also makes the watchdog boundary reachable: the bench checks that the block stays in slave mode after 127 VCLK edges and leaves after the 128th. Random address and length runs are mixed with directed checks of write protect, a rejected control byte and a byte abandoned partway through.

// File: rtl/edid_chan_pkg.sv
package edid_chan_pkg;
  typedef enum logic {M_STREAM, M_BIDIR} mode_e;
  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_ADDR, S_WDATA, S_ACK, S_RDATA, S_RACK
  } slv_state_e;
endpackage

// File: rtl/edid_sync.sv
module edid_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    logic       prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff_q   <= {2{RST_VAL[g]}};
        prev_q <= RST_VAL[g];
      end else begin
        ff_q   <= {ff_q[0], async_i[g]};
        prev_q <= ff_q[1];
      end
    end
    assign lvl_o[g]  = ff_q[1];
    assign prev_o[g] = prev_q;
  end
endmodule

// File: rtl/edid_table.sv
module edid_table #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'(i * 29 + 7);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/edid_slave.sv
module edid_slave
  import edid_chan_pkg::*;
#(
  parameter int         AW     = 7,
  parameter logic [3:0] PREFIX = 4'b1010
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          scl_lvl_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_lvl_i,
  input  logic          sda_rise_i,
  input  logic          sda_fall_i,
  input  logic          wp_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic          addr_hit_o,
  output logic          ptr_load_o,
  output logic [AW-1:0] ptr_val_o,
  output logic          ptr_inc_o,
  output logic          wr_en_o,
  output logic [7:0]    wr_data_o
);
  slv_state_e st_q, ack_nxt_q;
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic       oe_q, mack_q;

  logic start_c, stop_c, byte_done, ctrl_ok;
  assign start_c   = scl_lvl_i & sda_fall_i;
  assign stop_c    = scl_lvl_i & sda_rise_i;
  assign byte_done = scl_fall_i && (cnt_q == 4'd8);
  assign ctrl_ok   = (sh_q[7:4] == PREFIX);

  always_comb begin
    addr_hit_o = en_i && (st_q == S_CTRL) && byte_done && ctrl_ok;
    ptr_load_o = en_i && (st_q == S_ADDR) && byte_done;
    ptr_val_o  = sh_q[AW-1:0];
    wr_en_o    = en_i && (st_q == S_WDATA) && byte_done && !wp_i;
    wr_data_o  = sh_q;
    ptr_inc_o  = en_i && byte_done && ((st_q == S_WDATA) || (st_q == S_RDATA));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      ack_nxt_q <= S_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      oe_q      <= 1'b0;
      mack_q    <= 1'b0;
    end else if (!en_i) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (start_c) begin
      st_q  <= S_CTRL;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_c) begin
      st_q <= S_IDLE;
      oe_q <= 1'b0;
    end else begin
      case (st_q)
        S_CTRL, S_ADDR, S_WDATA: begin
          if (scl_rise_i && cnt_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_lvl_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            if (st_q == S_CTRL && !ctrl_ok) begin
              st_q <= S_IDLE;
            end else begin
              oe_q <= 1'b1;
              st_q <= S_ACK;
              if (st_q == S_CTRL) ack_nxt_q <= sh_q[0] ? S_RDATA : S_ADDR;
              else                ack_nxt_q <= S_WDATA;
            end
          end
        end
        S_ACK: begin
          if (scl_fall_i) begin
            st_q <= ack_nxt_q;
            if (ack_nxt_q == S_RDATA) begin
              sh_q  <= rd_data_i;
              oe_q  <= ~rd_data_i[7];
              cnt_q <= 4'd1;
            end else begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
            end
          end
        end
        S_RDATA: begin
          if (scl_fall_i) begin
            if (cnt_q < 4'd8) begin
              oe_q  <= ~sh_q[3'd7 - cnt_q[2:0]];
              cnt_q <= cnt_q + 4'd1;
            end else begin
              oe_q <= 1'b0;
              st_q <= S_RACK;
            end
          end
        end
        S_RACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              sh_q  <= rd_data_i;
              oe_q  <= ~rd_data_i[7];
              cnt_q <= 4'd1;
              st_q  <= S_RDATA;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  // R9
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(sda_oe_o)) |-> !scl_lvl_i);
endmodule

// File: rtl/edid_dual_chan.sv
module edid_dual_chan
  import edid_chan_pkg::*;
#(
  parameter int         TABLE_DEPTH = 128,
  parameter int         VCLK_LIMIT  = 128,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vclk_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o,
  output logic bidir_mode_o
);
  localparam int AW = $clog2(TABLE_DEPTH);
  localparam int CW = $clog2(VCLK_LIMIT);

  // bit 0 vclk, bit 1 scl, bit 2 sda
  logic [2:0] lvl, prv;
  edid_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk_i, .rst_ni, .async_i({sda_i, scl_i, vclk_i}), .lvl_o(lvl), .prev_o(prv)
  );

  logic vclk_rise, scl_rise, scl_fall, sda_rise, sda_fall;
  assign vclk_rise = lvl[0] & ~prv[0];
  assign scl_rise  = lvl[1] & ~prv[1];
  assign scl_fall  = ~lvl[1] & prv[1];
  assign sda_rise  = lvl[2] & ~prv[2];
  assign sda_fall  = ~lvl[2] & prv[2];

  mode_e         mode_q;
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] vcnt_q;
  logic [3:0]    sbit_q;
  logic          soe_q;
  logic [7:0]    rd_data;

  logic          slv_en, slv_oe, slv_hit, slv_load, slv_inc, slv_we;
  logic [AW-1:0] slv_ptr;
  logic [7:0]    slv_wdata;
  assign slv_en = (mode_q == M_BIDIR);

  edid_table #(.DEPTH(TABLE_DEPTH), .AW(AW)) u_table (
    .clk_i, .rst_ni, .we_i(slv_we), .waddr_i(ptr_q), .wdata_i(slv_wdata),
    .raddr_i(ptr_q), .rdata_o(rd_data)
  );

  edid_slave #(.AW(AW), .PREFIX(DEV_PREFIX)) u_slave (
    .clk_i, .rst_ni, .en_i(slv_en),
    .scl_lvl_i(lvl[1]), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(lvl[2]), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .wp_i, .rd_data_i(rd_data), .sda_oe_o(slv_oe), .addr_hit_o(slv_hit),
    .ptr_load_o(slv_load), .ptr_val_o(slv_ptr), .ptr_inc_o(slv_inc),
    .wr_en_o(slv_we), .wr_data_o(slv_wdata)
  );

  logic cur_bit, byte_end;
  assign cur_bit  = (sbit_q == 4'd8) ? 1'b1 : rd_data[3'd7 - sbit_q[2:0]];
  assign byte_end = (sbit_q == 4'd8);

  logic [AW-1:0] ptr_nxt;
  assign ptr_nxt = (ptr_q == AW'(TABLE_DEPTH - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_STREAM;
      sbit_q <= '0;
      soe_q  <= 1'b0;
      vcnt_q <= '0;
    end else if (mode_q == M_STREAM) begin
      if (scl_fall) begin
        mode_q <= M_BIDIR;
        soe_q  <= 1'b0;
        sbit_q <= '0;
        vcnt_q <= '0;
      end else if (vclk_rise) begin
        soe_q  <= ~cur_bit;
        sbit_q <= byte_end ? 4'd0 : sbit_q + 4'd1;
      end
    end else begin
      if (slv_hit) begin
        vcnt_q <= '0;
      end else if (vclk_rise) begin
        if (vcnt_q == CW'(VCLK_LIMIT - 1)) begin
          mode_q <= M_STREAM;
          vcnt_q <= '0;
        end else begin
          vcnt_q <= vcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           ptr_q <= '0;
    else if (mode_q == M_STREAM) begin
      if (!scl_fall && vclk_rise && byte_end)              ptr_q <= ptr_nxt;
    end else if (slv_load)                                 ptr_q <= slv_ptr;
    else if (slv_inc)                                      ptr_q <= ptr_nxt;
  end

  assign sda_oe_o     = (mode_q == M_STREAM) ? soe_q : slv_oe;
  assign bidir_mode_o = (mode_q == M_BIDIR);

  // R2
  stream_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_STREAM && !vclk_rise && !scl_fall) |=> $stable(sda_oe_o));
  // R4
  enter_bidir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_STREAM && scl_fall) |=> (bidir_mode_o && !sda_oe_o));
  // R6
  leave_bidir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bidir_mode_o) |-> ($past(vclk_rise) && !sda_oe_o));
  // R8
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_we |-> !wp_i);
endmodule

// File: tb/edid_dual_chan_test.sv
`timescale 1ns/1ps
module edid_dual_chan_test;
  logic clk = 1'b0, rst_n = 1'b0, vclk = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  wire  sda_oe, bidir;
  wire  sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  edid_dual_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .vclk_i(vclk), .scl_i(scl), .sda_i(sda_line),
    .wp_i(wp), .sda_oe_o(sda_oe), .bidir_mode_o(bidir)
  );

  int checks = 0, fails = 0;
  int ptr_m = 0;
  logic [7:0] model [128];

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 29 + 7);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n); repeat (n) @(negedge clk); endtask
  task automatic vpulse(); vclk = 1'b1; wt(4); vclk = 1'b0; wt(4); endtask
  task automatic vpulses(int n); for (int k = 0; k < n; k++) vpulse(); endtask

  task automatic stream_byte(output logic [7:0] b, output logic nine);
    b = '0;
    for (int k = 0; k < 8; k++) begin vpulse(); b = {b[6:0], sda_line}; end
    vpulse(); nine = sda_line;
  endtask

  task automatic stream_chk(string req);
    logic [7:0] b; logic n;
    stream_byte(b, n);
    chk(req, b, model[ptr_m]);
    chk(req, n, 1);
    ptr_m = (ptr_m + 1) % 128;
  endtask

  task automatic i_start(); sda_m = 1; wt(4); scl = 1; wt(4); sda_m = 0; wt(4); scl = 0; wt(4); endtask
  task automatic i_stop();  sda_m = 0; wt(4); scl = 1; wt(4); sda_m = 1; wt(4); endtask
  task automatic wbit(logic b); sda_m = b; wt(4); scl = 1; wt(4); scl = 0; wt(4); endtask
  task automatic rbit(output logic b); sda_m = 1; wt(4); scl = 1; wt(4); b = sda_line; scl = 0; wt(4); endtask

  task automatic send_byte(logic [7:0] d, output logic ack);
    logic b;
    for (int k = 7; k >= 0; k--) wbit(d[k]);
    rbit(b); ack = ~b;
  endtask

  task automatic recv_byte(logic mack, output logic [7:0] d);
    logic b;
    for (int k = 0; k < 8; k++) begin rbit(b); d = {d[6:0], b}; end
    wbit(~mack);
  endtask

  function automatic logic [7:0] ctrl(logic rd);
    logic [2:0] mid = 3'($urandom);
    return {4'b1010, mid, rd};
  endfunction

  task automatic write_seq(int addr, int n);
    logic ack; logic [7:0] d;
    i_start();
    send_byte(ctrl(1'b0), ack); chk("R5 write ctrl ack", ack, 1);
    send_byte({1'($urandom), 7'(addr)}, ack); chk("R7 addr ack", ack, 1);
    ptr_m = addr % 128;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk("R7 data ack", ack, 1);
      if (!wp) model[ptr_m] = d;
      ptr_m = (ptr_m + 1) % 128;
    end
    i_stop();
  endtask

  task automatic read_seq(int n);
    logic ack; logic [7:0] d;
    i_start();
    send_byte(ctrl(1'b1), ack); chk("R5 read ctrl ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk("R9 read data", d, model[ptr_m]);
      ptr_m = (ptr_m + 1) % 128;
    end
    chk("R9 release after nack", sda_oe, 0);
    i_stop();
  endtask

  task automatic bad_ctrl();
    logic ack;
    i_start();
    send_byte(8'h71, ack); chk("R5 reject ctrl", ack, 0);
    i_stop();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic held;
    void'($urandom(32'h5eed_2d41));
    for (int i = 0; i < 128; i++) model[i] = init_val(i);
    wt(5);
    // R1 reset state
    chk("R1 mode", bidir, 0);
    chk("R1 sda", sda_oe, 0);
    rst_n = 1'b1; wt(2);
    chk("R1 mode after reset", bidir, 0);

    // R2 stream MSB first, ninth bit high
    for (int k = 0; k < 3; k++) stream_chk("R2 stream byte");
    // R2 no change between VCLK edges
    vpulse(); held = sda_line; wt(20);
    chk("R2 hold", sda_line, held);
    vpulses(8); ptr_m = (ptr_m + 1) % 128;
    // R3 full table with wrap
    for (int k = 0; k < 128; k++) stream_chk("R3 stream wrap");

    // R4 abandon partial byte
    vpulses(3);
    scl = 1'b0; wt(6);
    chk("R4 enter bidir", bidir, 1);
    chk("R4 sda released", sda_oe, 0);
    read_seq(2);

    // R5 rejected control byte leaves pointer alone
    bad_ctrl();
    read_seq(1);

    // R7 write with wrap, R9 read with wrap
    write_seq(126, 4);
    write_seq(126, 0);
    read_seq(4);

    // R8 write protect
    wp = 1'b1; write_seq(10, 2); wp = 1'b0;
    write_seq(10, 0);
    read_seq(2);

    // R7 R9 random
    for (int it = 0; it < 20; it++) begin
      int a = int'($urandom_range(127, 0));
      int n = int'($urandom_range(5, 1));
      write_seq(a, n);
      write_seq(a, 0);
      read_seq(n);
    end

    // R6 acknowledged control byte restarts count, boundary 127/128
    vpulses(100);
    read_seq(1);
    vpulses(127);
    chk("R6 still bidir at 127", bidir, 1);
    vpulse();
    chk("R6 back to stream at 128", bidir, 0);
    chk("R6 sda released", sda_oe, 0);

    // R10 fresh byte at pointer
    stream_chk("R10 resume");

    // R6 rejected control byte does not restart count
    scl = 1'b0; wt(6);
    chk("R4 enter bidir again", bidir, 1);
    vpulses(120);
    bad_ctrl();
    vpulses(7);
    chk("R6 bidir before expiry", bidir, 1);
    vpulse();
    chk("R6 expiry after rejected ctrl", bidir, 0);
    stream_chk("R10 resume again");

    summary();
    $finish;
  end
endmodule